// File: doc/BRIEF.md
# Bus Ready Generator

This block produces the active-low ready strobe that ends a processor bus cycle. It serves two kinds of cycle. A display access targets a display controller or its memory. A halt cycle is recognised from the processor status lines. All other cycles get no external ready from this block. A display access first runs through a fixed number of wait T-states. After that it waits for the controller's active-low wait line to go high again. A halt cycle is acknowledged in the first T-state after it starts.

The bus timing arrives as a one-clock strobe, `t_adv`, which marks each T-state boundary. A new cycle is announced by `bus_start` at the same boundary. The display select, sampled when a cycle is accepted, chooses which of the two ready sources drives the output for that whole cycle. The wait line from the controller is asynchronous, so it passes through a flip-flop synchroniser before the sequencer looks at it. The sequencer states are `ST_IDLE`, `ST_WS` (wait states running), `ST_WAIT` (watching the synchronised wait line), `ST_DRDY` (display ready) and `ST_HRDY` (halt ready).

The transitions are:
- `ST_IDLE` to `ST_WS`: an accepted start while the display select is high.
- `ST_IDLE` to `ST_HRDY`: an accepted start with the halt pattern and the display select low.
- `ST_WS` to `ST_WAIT`: after `WAIT_STATES` boundaries.
- `ST_WAIT` to `ST_DRDY`: at a boundary where the synchronised wait line is high.
- `ST_DRDY` or `ST_HRDY` to `ST_IDLE`: at the next boundary.

Top module: `bus_ready_gen`

## Requirements
- R1: `ready_n` is high while `rst_n` is low and stays high after reset until a qualified cycle completes. A reset in the middle of a cycle returns the block to idle with `ready_n` high.
- R2: `ready_n` changes only at a clock edge where `t_adv` is high, so it is constant for the whole of each T-state.
- R3: When a cycle starts with `disp_sel`=0, `dc_n`=0, `mio_n`=1 and `wr_n`=1, `ready_n` is low in the first T-state after the start boundary.
- R4: A cycle started with `disp_sel`=0 and any other status pattern leaves `ready_n` high.
- R5: For a cycle started with `disp_sel`=1, `ready_n` stays high for the first `WAIT_STATES`+1 T-states after the start boundary (default 2 wait states, so ready at the earliest in T-state 4).
- R6: During a display access `ready_n` goes low only in the T-state after a boundary at which the synchronised `wait_n` is high. While `wait_n` is held low, `ready_n` stays high.
- R7: `wait_n` passes through `SYNC_STAGES` flip-flops (default 2). A rise only one clock before a boundary is not honoured until the following boundary.
- R8: Each completed cycle drives `ready_n` low for exactly one T-state and then high again.
- R9: When `disp_sel` is 1 at the start boundary, the display path drives `ready_n` and the halt status pattern has no effect.
- R10: A `bus_start` at a boundary while a cycle is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t_adv | input | 1 | One-clock strobe marking each T-state boundary |
| bus_start | input | 1 | A new bus cycle begins at this boundary |
| disp_sel | input | 1 | Display controller or display memory is addressed |
| dc_n | input | 1 | Status: data (1) / control (0) |
| mio_n | input | 1 | Status: memory (1) / I/O (0) |
| wr_n | input | 1 | Status: write (1) / read (0) |
| wait_n | input | 1 | Asynchronous active-low wait from the display controller |
| ready_n | output | 1 | Active-low ready to the processor |

## Verification
The hardest case to reach is the boundary between honouring a wait release and missing it. The synchroniser delay decides whether a rise of `wait_n` is seen at the next T-state boundary or one boundary later. The bench places the release at two precise clock positions inside a T-state: right after the previous boundary, and a single clock before the next one. It then checks that the ready T-state moves by exactly one. A restart request injected during the wait states, and a reset applied while the block waits on the peripheral, check that the sequencer cannot be pulled out of an in-flight cycle.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WS,
        ST_WAIT,
        ST_DRDY,
        ST_HRDY
    } rdy_state_e;

endpackage

// File: rtl/rdy_wait_sync.sv
module rdy_wait_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [SYNC_STAGES-1:0] chain_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/rdy_halt_decode.sv
module rdy_halt_decode (
    input  logic dc_n,
    input  logic mio_n,
    input  logic wr_n,
    output logic halt_hit
);
    // control cycle, memory space, write direction marks a halt
    always_comb begin
        halt_hit = (!dc_n) && mio_n && wr_n;
    end
endmodule

// File: rtl/rdy_seq.sv
module rdy_seq
    import rdy_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       t_adv,
    input  logic       bus_start,
    input  logic       disp_sel,
    input  logic       halt_hit,
    input  logic       wait_ok,
    output rdy_state_e state,
    output logic       path_disp,
    output logic       disp_rdy,
    output logic       halt_rdy
);
    localparam int CW = $clog2(WAIT_STATES) + 1;
    localparam logic [CW-1:0] WS_LAST = CW'(WAIT_STATES - 1);

    rdy_state_e st_q, st_d;
    logic [CW-1:0] ws_q, ws_d;
    logic path_q, path_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ws_q   <= '0;
            path_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ws_q   <= ws_d;
            path_q <= path_d;
        end
    end

    // transitions
    always_comb begin
        st_d   = st_q;
        ws_d   = ws_q;
        path_d = path_q;
        unique case (st_q)
            ST_IDLE: begin
                if (t_adv && bus_start) begin
                    path_d = disp_sel;
                    if (disp_sel) begin
                        st_d = ST_WS;
                        ws_d = '0;
                    end else if (halt_hit) begin
                        st_d = ST_HRDY;
                    end
                end
            end
            ST_WS: begin
                if (t_adv) begin
                    if (ws_q == WS_LAST) st_d = ST_WAIT;
                    else                 ws_d = ws_q + 1'b1;
                end
            end
            ST_WAIT: begin
                if (t_adv && wait_ok) st_d = ST_DRDY;
            end
            ST_DRDY, ST_HRDY: begin
                if (t_adv) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        disp_rdy  = (st_q == ST_DRDY);
        halt_rdy  = (st_q == ST_HRDY);
        state     = st_q;
        path_disp = path_q;
    end
endmodule

// File: rtl/rdy_out_mux.sv
module rdy_out_mux (
    input  logic path_disp,
    input  logic disp_rdy,
    input  logic halt_rdy,
    output logic ready_n
);
    always_comb begin
        if (path_disp) ready_n = !disp_rdy;
        else           ready_n = !halt_rdy;
    end
endmodule

// File: rtl/bus_ready_gen.sv
module bus_ready_gen
    import rdy_pkg::*;
#(
    parameter int WAIT_STATES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic t_adv,
    input  logic bus_start,
    input  logic disp_sel,
    input  logic dc_n,
    input  logic mio_n,
    input  logic wr_n,
    input  logic wait_n,
    output logic ready_n
);
    logic       wait_s;
    logic       halt_hit;
    logic       path_disp;
    logic       disp_rdy;
    logic       halt_rdy;
    rdy_state_e st_q;

    rdy_wait_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wait_n),
        .sync_out (wait_s)
    );

    rdy_halt_decode u_halt (
        .dc_n     (dc_n),
        .mio_n    (mio_n),
        .wr_n     (wr_n),
        .halt_hit (halt_hit)
    );

    rdy_seq #(.WAIT_STATES(WAIT_STATES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .t_adv     (t_adv),
        .bus_start (bus_start),
        .disp_sel  (disp_sel),
        .halt_hit  (halt_hit),
        .wait_ok   (wait_s),
        .state     (st_q),
        .path_disp (path_disp),
        .disp_rdy  (disp_rdy),
        .halt_rdy  (halt_rdy)
    );

    rdy_out_mux u_mux (
        .path_disp (path_disp),
        .disp_rdy  (disp_rdy),
        .halt_rdy  (halt_rdy),
        .ready_n   (ready_n)
    );
endmodule

// File: rtl/rdy_checker.sv
module rdy_checker
    import rdy_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       t_adv,
    input logic       bus_start,
    input logic       disp_sel,
    input logic       dc_n,
    input logic       mio_n,
    input logic       wr_n,
    input logic       ready_n,
    input rdy_state_e state,
    input logic       path_disp,
    input logic       wait_sync
);
    logic [7:0] ts_cnt;
    logic       accept;
    logic       halt_pat;

    assign accept   = (state == ST_IDLE) && t_adv && bus_start;
    assign halt_pat = !dc_n && mio_n && wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        ts_cnt <= '0;
        else if (accept)                   ts_cnt <= 8'd1;
        else if (t_adv && ts_cnt != 8'hFF) ts_cnt <= ts_cnt + 8'd1;
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> ready_n);  // R1

    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ready_n) |-> $past(t_adv));  // R2

    AST_HALT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !disp_sel && halt_pat) |=> !ready_n);  // R3

    AST_OTHER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !disp_sel && !halt_pat) |=> (ready_n && state == ST_IDLE));  // R4

    AST_DISP_WAIT_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready_n) && path_disp) |-> (ts_cnt >= 8'(WAIT_STATES + 2)));  // R5

    AST_WAIT_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready_n) && path_disp) |-> $past(wait_sync));  // R6

    AST_ONE_TSTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n && t_adv) |=> ready_n);  // R8

    AST_DISP_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && disp_sel) |=> (ready_n && path_disp));  // R9
endmodule

bind bus_ready_gen rdy_checker #(.WAIT_STATES(WAIT_STATES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_adv     (t_adv),
    .bus_start (bus_start),
    .disp_sel  (disp_sel),
    .dc_n      (dc_n),
    .mio_n     (mio_n),
    .wr_n      (wr_n),
    .ready_n   (ready_n),
    .state     (st_q),
    .path_disp (path_disp),
    .wait_sync (wait_s)
);

// File: tb/test_bus_ready_gen.sv
module test_bus_ready_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic t_adv = 1'b0;
    logic bus_start = 1'b0;
    logic disp_sel = 1'b0;
    logic dc_n = 1'b1;
    logic mio_n = 1'b1;
    logic wr_n = 1'b1;
    logic wait_n = 1'b1;
    logic ready_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_ready_gen i_bus_ready_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .t_adv     (t_adv),
        .bus_start (bus_start),
        .disp_sel  (disp_sel),
        .dc_n      (dc_n),
        .mio_n     (mio_n),
        .wr_n      (wr_n),
        .wait_n    (wait_n),
        .ready_n   (ready_n)
    );

    // [12]disp [11]dc_n [10]mio_n [9]wr_n [8:5]release T-state [4]restart [3:0]expected ready T-state
    localparam logic [12:0] VEC [10] = '{
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'd1},
        {1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0},
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd4},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 1'b0, 4'd4},
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 1'b0, 4'd4},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd5, 1'b0, 4'd6},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'd4},
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1, 4'd5}
    };

    function automatic string vec_tag(input int idx);
        case (idx)
            0:       return "R3";
            1, 2, 3: return "R4";
            4, 5:    return "R5";
            6, 7:    return "R6";
            8:       return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one T-state: boundary edge, then sample mid T-state and check it holds (R2)
    task automatic tstep(input logic start, input logic rel_now, input logic late_rel,
                         output logic smp);
        @(negedge clk);
        t_adv = 1'b1;
        bus_start = start;
        if (late_rel) wait_n = 1'b1;
        @(negedge clk);
        t_adv = 1'b0;
        bus_start = 1'b0;
        smp = ready_n;
        if (rel_now) wait_n = 1'b1;
        @(negedge clk);
        check("R2", int'(ready_n), int'(smp));
        @(negedge clk);
        check("R2", int'(ready_n), int'(smp));
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic smp;
        int first;
        int lows;

        repeat (3) @(negedge clk);
        check("R1", int'(ready_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", int'(ready_n), 1);

        // vector table
        for (int v = 0; v < 10; v++) begin
            logic [12:0] e;
            e = VEC[v];
            disp_sel = e[12];
            dc_n = e[11];
            mio_n = e[10];
            wr_n = e[9];
            wait_n = (e[8:5] == 4'd0);
            first = 0;
            lows = 0;
            for (int k = 1; k <= 10; k++) begin
                logic st;
                st = (k == 1);
                if (k == 2 && e[4]) begin
                    disp_sel = 1'b0; dc_n = 1'b0; mio_n = 1'b1; wr_n = 1'b1;
                    st = 1'b1;
                end
                tstep(st, (int'(e[8:5]) == k), 1'b0, smp);
                if (!smp) begin
                    lows++;
                    if (first == 0) first = k;
                end
            end
            check(vec_tag(v), first, int'(e[3:0]));
            check("R8", lows, (e[3:0] != 4'd0) ? 1 : 0);
            disp_sel = 1'b0; dc_n = 1'b1; mio_n = 1'b1; wr_n = 1'b1; wait_n = 1'b1;
        end

        // R7: release one clock before a boundary is seen one boundary later
        disp_sel = 1'b1; dc_n = 1'b1; mio_n = 1'b0; wr_n = 1'b0; wait_n = 1'b0;
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            tstep(k == 1, 1'b0, k == 4, smp);
            if (!smp && first == 0) first = k;
        end
        check("R7", first, 5);
        disp_sel = 1'b0; wait_n = 1'b1;

        // R6: wait held low for a long time keeps ready high
        disp_sel = 1'b1; wait_n = 1'b0;
        lows = 0;
        for (int k = 1; k <= 9; k++) begin
            tstep(k == 1, 1'b0, 1'b0, smp);
            if (!smp) lows++;
        end
        check("R6", lows, 0);

        // R1: reset while waiting on the peripheral
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", int'(ready_n), 1);
        wait_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1", int'(ready_n), 1);
        for (int k = 1; k <= 3; k++) begin
            tstep(1'b0, 1'b0, 1'b0, smp);
            check("R1", int'(smp), 1);
        end
        // halt cycle after reset
        disp_sel = 1'b0; dc_n = 1'b0; mio_n = 1'b1; wr_n = 1'b1;
        tstep(1'b1, 1'b0, 1'b0, smp);
        check("R3", int'(smp), 0);
        tstep(1'b0, 1'b0, 1'b0, smp);
        check("R8", int'(smp), 1);

        done = 1'b1;
        finish_up();
    end

endmodule